// File: doc/BRIEF.md
# Programmable Integer Clock Divider with Duty Control

This block turns one fast input clock into a slower clock whose period is a whole number N of input cycles. A cycle counter runs from 0 up to N-1 and then starts over, and each pass through the counter is one output period. The shape of the output within a period comes from one of three modes. The level mode drives the output high for the first H input cycles of the period. The half mode gives an exact 50% duty cycle. For odd N it reaches this by ANDing a term registered on the rising edge with a copy of that term retimed on the falling edge. The pulse mode gives a single-cycle high pulse once per period, using rising-edge registers only.

The ratio, the high count and the mode can change at any time. The block captures them only at the rising edge that begins a new period, so a setting never cuts a period short or glitches it. The output is always taken from register outputs. It never comes from a counter bit, because a counter bit gives an uneven duty cycle whenever N is not a power of two.

Top module: `clk_div_prog`

## Requirements
- R1: Every output period lasts exactly N input clock cycles. The internal count steps through 0, 1, ..., N-1 and returns to 0 on the rising edge that starts the next period.
- R2: While `rst_ni` is low, the output is low at once and the count is held at 0. The first rising edge after release starts a new period and loads the current settings.
- R3: With `mode_i` = 2'b00 (level mode), the output is high during counts 0 through H-1 and low during the rest of the period.
- R4: With `mode_i` = 2'b01 (half mode) and N even, the output is high for counts 0 through N/2-1 and low for the other N/2 cycles.
- R5: With `mode_i` = 2'b01 and N odd, the output rises at the falling edge within count 0 and falls at the rising edge that begins count (N+1)/2. That gives N/2 input periods high, to the half cycle.
- R6: With `mode_i` = 2'b10 (pulse mode), the output is high during count 0 only, which is one input cycle out of every N.
- R7: A ratio value of 0 or 1 is used as 2.
- R8: In level mode, H = 0 holds the output low for the whole period, and any H of N or more holds it high for the whole period.
- R9: A change on `ratio_i`, `high_i` or `mode_i` in the middle of a period has no effect on the output until the rising edge that starts the next period. That edge captures the values present at it.
- R10: `mode_i` = 2'b11 behaves exactly as level mode.
- R11: In half mode with N odd, the first half of count 0 keeps the level the output had in the half cycle just before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock; both edges are used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | CNT_W | Division ratio N; values below 2 act as 2 |
| high_i | input | CNT_W | High time H in input cycles, used in level mode |
| mode_i | input | 2 | 00 level, 01 half (50%), 10 single pulse, 11 level |
| clk_o | output | 1 | Divided clock |

## Verification
Capturing new settings and starting a new period always happen on the same rising edge. The bench provokes this by changing the ratio, the high count and the mode in the middle of a period, including a move from a constantly high level setting straight into odd half mode. The reference model holds the old values until its own count wraps and predicts the level in each half of every input cycle, which also checks how the falling-edge term carries over across the boundary. A reset applied in the middle of a period is judged the same way: the output must go low and the restart must fall on the first edge after release.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

    typedef enum logic [1:0] {
        MODE_LEVEL = 2'b00,
        MODE_HALF  = 2'b01,
        MODE_PULSE = 2'b10,
        MODE_ALT   = 2'b11
    } mode_e;

endpackage

// File: rtl/cdp_counter.sv
// Period counter and settings capture. Settings are taken only on the
// edge that starts a period; the first edge after reset always starts one.
module cdp_counter
    import cdp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] ratio_i,
    input  logic [CNT_W-1:0] high_i,
    input  logic [1:0]       mode_i,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic [CNT_W-1:0] n_d_o,
    output logic [CNT_W-1:0] h_d_o,
    output mode_e            mode_d_o,
    output logic [CNT_W-1:0] n_q_o,
    output mode_e            mode_q_o
);

    localparam logic [CNT_W-1:0] N_MIN = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    typedef struct packed {
        logic             fresh;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] n;
        logic [CNT_W-1:0] h;
        mode_e            mode;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = st_q.fresh || (st_q.cnt >= (st_q.n - ONE));
        if (wrap) begin
            st_d.fresh = 1'b0;
            st_d.cnt   = '0;
            st_d.n     = (ratio_i < N_MIN) ? N_MIN : ratio_i;
            st_d.h     = high_i;
            st_d.mode  = mode_e'(mode_i);
        end else begin
            st_d.cnt   = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{fresh: 1'b1, cnt: '0, n: N_MIN, h: '0, mode: MODE_LEVEL};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_d_o  = st_d.cnt;
    assign n_d_o    = st_d.n;
    assign h_d_o    = st_d.h;
    assign mode_d_o = st_d.mode;
    assign n_q_o    = st_q.n;
    assign mode_q_o = st_q.mode;

endmodule

// File: rtl/cdp_wave.sv
// Rising-edge output term, computed from the next count and settings so
// that the registered term lines up with the registered count.
module cdp_wave
    import cdp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_d_i,
    input  logic [CNT_W-1:0] n_d_i,
    input  logic [CNT_W-1:0] h_d_i,
    input  mode_e            mode_d_i,
    output logic             rise_q_o
);

    logic             rise_d, rise_q;
    logic [CNT_W-1:0] half_thr;

    always_comb begin
        // even N: N/2 cycles; odd N: (N+1)/2 cycles, trimmed later by the falling term
        half_thr = (n_d_i >> 1) + CNT_W'(n_d_i[0]);
        unique case (mode_d_i)
            MODE_HALF:  rise_d = (cnt_d_i < half_thr);
            MODE_PULSE: rise_d = (cnt_d_i == '0);
            default:    rise_d = (cnt_d_i < h_d_i);
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rise_q <= 1'b0;
        end else begin
            rise_q <= rise_d;
        end
    end

    assign rise_q_o = rise_q;

endmodule

// File: rtl/cdp_fall.sv
// Retimes the rising-edge term by half an input cycle.
module cdp_fall (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    output logic fall_q_o
);

    logic fall_d, fall_q;

    always_comb begin
        fall_d = rise_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= fall_d;
        end
    end

    assign fall_q_o = fall_q;

endmodule

// File: rtl/clk_div_prog.sv
module clk_div_prog
    import cdp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] ratio_i,
    input  logic [CNT_W-1:0] high_i,
    input  logic [1:0]       mode_i,
    output logic             clk_o
);

    logic [CNT_W-1:0] cnt_d, n_d, h_d, n_q;
    mode_e            mode_d, mode_q;
    logic             rise_q, fall_q, odd_half;

    cdp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ratio_i  (ratio_i),
        .high_i   (high_i),
        .mode_i   (mode_i),
        .cnt_d_o  (cnt_d),
        .n_d_o    (n_d),
        .h_d_o    (h_d),
        .mode_d_o (mode_d),
        .n_q_o    (n_q),
        .mode_q_o (mode_q)
    );

    cdp_wave #(.CNT_W(CNT_W)) u_wave (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cnt_d_i  (cnt_d),
        .n_d_i    (n_d),
        .h_d_i    (h_d),
        .mode_d_i (mode_d),
        .rise_q_o (rise_q)
    );

    cdp_fall u_fall (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rise_i   (rise_q),
        .fall_q_o (fall_q)
    );

    // Only odd half mode needs the falling-edge term; both inputs are flops.
    assign odd_half = (mode_q == MODE_HALF) && n_q[0];
    assign clk_o    = rise_q & (odd_half ? fall_q : 1'b1);

endmodule

// File: rtl/clk_div_prog_chk.sv
module cdp_counter_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] n_q,
    input logic [CNT_W-1:0] h_q,
    input logic [1:0]       mode_q
);

    assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < n_q);

    assert_ratio_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        n_q >= CNT_W'(2));

    assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0) |-> ($stable(n_q) && $stable(h_q) && $stable(mode_q)));

endmodule

module clk_div_prog_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic clk_o
);

    assert_reset_low_R2: assert property (@(posedge clk_i)
        !rst_ni |-> !clk_o);

endmodule

bind cdp_counter cdp_counter_chk #(.CNT_W(CNT_W)) u_cnt_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_q  (st_q.cnt),
    .n_q    (st_q.n),
    .h_q    (st_q.h),
    .mode_q (st_q.mode)
);

bind clk_div_prog clk_div_prog_chk u_top_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clk_o  (clk_o)
);

// File: tb/clk_div_prog_bench.sv
module clk_div_prog_bench;

    localparam int CLK_P = 20;
    localparam int W     = 16;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ratio = 16'd4;
    logic [W-1:0] high  = 16'd2;
    logic [1:0]   mode  = 2'b00;
    logic         clk_o;

    int    checks = 0;
    int    errors = 0;
    string req    = "R2";

    // reference model state
    int n_act   = 2;
    int h_act   = 0;
    int m_act   = 0;
    int pos     = 0;
    bit started = 1'b0;
    bit prev2   = 1'b0;
    bit e1      = 1'b0;
    bit e2      = 1'b0;

    clk_div_prog #(.CNT_W(W)) u_clk_div_prog (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .ratio_i (ratio),
        .high_i  (high),
        .mode_i  (mode),
        .clk_o   (clk_o)
    );

    initial forever #(CLK_P/2) clk = ~clk;

    task automatic model_edge();
        if (!started || pos >= n_act - 1) begin
            n_act   = (int'(ratio) < 2) ? 2 : int'(ratio);
            h_act   = int'(high);
            m_act   = int'(mode);
            pos     = 0;
            started = 1'b1;
        end else begin
            pos++;
        end
        case (m_act)
            1: begin
                if (n_act % 2 == 0) begin
                    e2 = (pos < n_act / 2);
                    e1 = e2;
                end else begin
                    e2 = (pos <= (n_act - 1) / 2);
                    e1 = (pos == 0) ? prev2 : e2;
                end
            end
            2: begin
                e2 = (pos == 0);
                e1 = e2;
            end
            default: begin
                e2 = (pos < h_act);
                e1 = e2;
            end
        endcase
        prev2 = e2;
    endtask

    task automatic chk(input logic got, input bit exp, input string where);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: clk_o=%b expected %b (N=%0d H=%0d mode=%0d count=%0d) t=%0t",
                     req, where, got, exp, n_act, h_act, m_act, pos, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (!rst_n) begin
            started = 1'b0;
            prev2   = 1'b0;
            e1      = 1'b0;
            e2      = 1'b0;
        end else begin
            model_edge();
        end
        #4  chk(clk_o, e1, "first half");
        #10 chk(clk_o, e2, "second half");
    endtask

    task automatic run(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic set(input int r, input int h, input int m);
        ratio = W'(r);
        high  = W'(h);
        mode  = 2'(m);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        // R2: reset state, then release
        req = "R2";
        #2 chk(clk_o, 1'b0, "during reset");
        run(4);
        set(6, 1, 0);
        rst_n = 1'b1;
        // R1: period length and wrap
        req = "R1";
        run(24);
        // R3: level mode high time
        req = "R3";
        set(10, 3, 0);
        run(30);
        set(56818, 17045, 0);
        run(56818 + 12);
        // R2: reset in the middle of a period, restart on release
        req = "R2";
        rst_n = 1'b0;
        #1 chk(clk_o, 1'b0, "async reset");
        run(2);
        set(8, 0, 1);
        rst_n = 1'b1;
        // R4: half mode, even ratios
        req = "R4";
        run(32);
        set(2, 0, 1);
        run(12);
        // R5: half mode, odd ratios
        req = "R5";
        set(3, 0, 1);
        run(15);
        set(7, 0, 1);
        run(30);
        set(9, 0, 1);
        run(40);
        // R6: pulse mode
        req = "R6";
        set(3, 0, 2);
        run(15);
        set(5, 0, 2);
        run(20);
        // R7: ratios below two
        req = "R7";
        set(1, 1, 0);
        run(10);
        set(0, 1, 0);
        run(10);
        // R8: high-count extremes
        req = "R8";
        set(6, 0, 0);
        run(18);
        set(6, 6, 0);
        run(18);
        set(6, 40, 0);
        run(18);
        // R11: constant high straight into odd half mode
        req = "R11";
        set(5, 9, 0);
        run(12);
        set(5, 0, 1);
        run(20);
        // R9: settings changed mid-period wait for the wrap
        req = "R9";
        set(12, 6, 0);
        run(14);
        set(5, 2, 1);
        run(3);
        set(7, 3, 2);
        run(4);
        set(5, 2, 1);
        run(20);
        // R10: mode 11 acts as level mode
        req = "R10";
        set(6, 2, 3);
        run(18);
        set(9, 4, 3);
        run(27);
        summary();
        $finish;
    end

endmodule